// File: doc/BRIEF.md
# Successive-Approximation Conversion and Power Sequencer

This block is the digital control core of a 10-bit successive-approximation converter. A single conversion-start strobe drives it. A rising edge on the strobe wakes the block from its low-power state and enables the serial read port. A falling edge ends tracking and starts a conversion. The level of the strobe when a conversion finishes decides whether the block stays powered for the next sample or powers itself down.

A conversion runs one bit trial per result bit, most significant bit first. The block drives a trial word to an external charge DAC and reads a one-bit comparator back. The finished code is straight binary, one LSB being the reference over 1024. It goes to a result register and to a 16-bit output shift register, which a reader clocks out over a two-wire port (serial clock in, data out). A result that arrives while a read is under way is held back until that read has finished, so the frame being read is never corrupted. The strobe and the serial clock are sampled by the system clock, and every duration is given in system-clock cycles.

Top module: `sar_seq`

## Requirements
- R1: After reset, status_o is 0 (off), dout_o is 0 and dac_o is 0.
- R2: In the off state a rising edge of conv_start_i moves status_o to 1 (powering up) for PWR_CYC cycles, then to 2 (tracking), and enables the serial port. A rising edge in any other state only enables the port.
- R3: A falling edge of conv_start_i while tracking moves status_o to 3 (converting) for exactly N*(SETTLE+1) cycles. Falling edges while off or powering up are ignored.
- R4: During a conversion, each trial sets its bit in dac_o, starting at bit N-1, and holds it for SETTLE+1 cycles. The bit is kept if cmp_i is 1 on the trial's last cycle and cleared otherwise. With an ideal comparator (cmp_i = input >= dac_o), the result equals the input code, saturating at 1023.
- R5: If conv_start_i is high on the cycle the conversion ends, status_o returns to 2 (tracking).
- R6: If conv_start_i is low on the cycle the conversion ends, status_o goes to 0 (off) and the serial port is disabled.
- R7: A frame is 16 bits, MSB first: six zero bits, then the 10-bit result. A read starts at a rising sclk_i edge while the port is enabled and ends at its 16th falling edge. dout_o changes only after a falling sclk_i edge or when a new result is loaded.
- R8: A read that starts before the current conversion ends returns the previous result.
- R9: If a conversion ends during a read, the new result is loaded into the shift register only when that read ends. The next read returns it.
- R10: sclk_i has no effect while the port is disabled and no read is active. dout_o stays unchanged, and the frame is delivered intact once the port is enabled again.
- R11: dac_o is 0 whenever status_o is not 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start_i | input | 1 | Conversion-start strobe (rise: wake and enable the port; fall: start a conversion) |
| cmp_i | input | 1 | Comparator: 1 when the sample is at or above the DAC level |
| sclk_i | input | 1 | Serial read clock from the reader |
| dout_o | output | 1 | Serial data out, MSB first |
| dac_o | output | N | Trial word to the charge DAC |
| status_o | output | 2 | 0 off, 1 powering up, 2 tracking, 3 converting |

## Verification
The assertions check on every cycle the legal state transitions: how the block leaves off, how a conversion is entered, and how the strobe level picks the state after a conversion. They also check that the first trial word is the MSB, that the DAC word is idle outside conversion, and that the serial data moves only after a falling serial-clock edge or a result load. Only the bench's scenarios can show what the frames carry. The converted codes, including saturation, the previous result on an early read, a result held back until an overlapping read ends, and a frame left untouched by clocks while powered down, are all compared against a cycle-by-cycle reference model.

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int N       = 10,
  parameter int FRAME   = 16,
  parameter int PWR_CYC = 188,
  parameter int SETTLE  = 27
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         conv_start_i,
  input  logic         cmp_i,
  input  logic         sclk_i,
  output logic         dout_o,
  output logic [N-1:0] dac_o,
  output logic [1:0]   status_o
);

  localparam int PW = $clog2(PWR_CYC + 1);
  localparam int TW = $clog2(SETTLE + 2);
  localparam int KW = (N > 1) ? $clog2(N) : 1;
  localparam int BW = $clog2(FRAME + 1);

  typedef enum logic [1:0] {S_OFF = 2'd0, S_PUP = 2'd1, S_TRK = 2'd2, S_CNV = 2'd3} st_t;

  st_t             st;
  logic            strobe_q, sclk_q;
  logic [PW-1:0]   pcnt;
  logic [TW-1:0]   tcnt;
  logic [KW-1:0]   kidx;
  logic [N-1:0]    dac_q, res_q;
  logic [FRAME-1:0] sh_q;
  logic            port_en, rd_act;
  logic [BW-1:0]   bcnt;

  wire strobe_rise = conv_start_i & ~strobe_q;
  wire strobe_fall = ~conv_start_i & strobe_q;
  wire sclk_rise   = sclk_i & ~sclk_q;
  wire sclk_fall   = ~sclk_i & sclk_q;

  wire          trial_end = (st == S_CNV) && (tcnt == TW'(SETTLE));
  wire          conv_done = trial_end && (kidx == '0);
  wire [N-1:0]  kbit      = N'(1) << kidx;
  wire [N-1:0]  trial_val = cmp_i ? dac_q : (dac_q & ~kbit);
  wire          read_end  = rd_act && sclk_fall && (bcnt == BW'(FRAME - 1));
  wire          load_sh   = read_end || (conv_done && !rd_act);
  wire [N-1:0]  load_val  = conv_done ? trial_val : res_q;

  assign dout_o   = sh_q[FRAME-1];
  assign dac_o    = dac_q;
  assign status_o = st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_OFF;
      strobe_q <= 1'b0;
      sclk_q   <= 1'b0;
      pcnt     <= '0;
      tcnt     <= '0;
      kidx     <= '0;
      dac_q    <= '0;
      res_q    <= '0;
    end else begin
      strobe_q <= conv_start_i;
      sclk_q   <= sclk_i;
      case (st)
        S_OFF: if (strobe_rise) begin
          st   <= S_PUP;
          pcnt <= '0;
        end
        S_PUP: begin
          if (pcnt == PW'(PWR_CYC - 1)) st <= S_TRK;
          else pcnt <= pcnt + 1'b1;
        end
        S_TRK: if (strobe_fall) begin
          st    <= S_CNV;
          kidx  <= KW'(N - 1);
          tcnt  <= '0;
          dac_q <= {1'b1, {(N-1){1'b0}}};
        end
        S_CNV: begin
          if (trial_end) begin
            if (kidx == '0) begin
              res_q <= trial_val;
              dac_q <= '0;
              st    <= conv_start_i ? S_TRK : S_OFF;
            end else begin
              dac_q <= trial_val | (kbit >> 1);
              kidx  <= kidx - 1'b1;
              tcnt  <= '0;
            end
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: st <= S_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_en <= 1'b0;
      rd_act  <= 1'b0;
      bcnt    <= '0;
      sh_q    <= '0;
    end else begin
      if (strobe_rise) port_en <= 1'b1;
      else if (conv_done && !conv_start_i) port_en <= 1'b0;

      if (load_sh) sh_q <= {{(FRAME-N){1'b0}}, load_val};
      else if (rd_act && sclk_fall) sh_q <= sh_q << 1;

      if (read_end) begin
        rd_act <= 1'b0;
      end else if (!rd_act && sclk_rise && port_en) begin
        rd_act <= 1'b1;
        bcnt   <= '0;
      end
      if (rd_act && sclk_fall) bcnt <= bcnt + 1'b1;
    end
  end

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int N = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic         conv_start_i,
  input logic         sclk_i,
  input logic         dout_o,
  input logic [N-1:0] dac_o,
  input logic [1:0]   status_o
);

  a_r1_reset_off: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (status_o == 2'd0 && dac_o == '0 && !dout_o));

  a_r2_wake_path: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(status_o) == 2'd0 && status_o != 2'd0) |-> (status_o == 2'd1 && $past(conv_start_i)));

  a_r3_conv_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == 2'd3 && $past(status_o) != 2'd3) |-> ($past(status_o) == 2'd2 && !$past(conv_start_i)));

  a_r4_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == 2'd3 && $past(status_o) != 2'd3) |-> dac_o == {1'b1, {(N-1){1'b0}}});

  a_r5_end_level: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(status_o) == 2'd3 && status_o != 2'd3) |-> status_o == ($past(conv_start_i) ? 2'd2 : 2'd0));

  a_r7_dout_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_o != $past(dout_o)) |-> (($past(sclk_i, 2) && !$past(sclk_i)) || $past(status_o) == 2'd3));

  a_r11_dac_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o != 2'd3) |-> dac_o == '0);

endmodule

bind sar_seq sar_seq_chk #(.N(N)) chk_i (
  .clk(clk), .rst_n(rst_n), .conv_start_i(conv_start_i), .sclk_i(sclk_i),
  .dout_o(dout_o), .dac_o(dac_o), .status_o(status_o)
);

// File: tb/sar_seq_tb_top.sv
module sar_seq_tb_top;
  localparam int N = 10, FRAME = 16, PWR = 5, SET = 2;
  localparam int CONVT = N * (SET + 1);

  logic clk = 1'b0, rst_n = 1'b0, strobe = 1'b0, sclk = 1'b0;
  int vin = 0;
  logic cmp, dout;
  logic [N-1:0] dac;
  logic [1:0] status;
  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;
  assign cmp = (vin >= int'(dac));

  sar_seq #(.N(N), .FRAME(FRAME), .PWR_CYC(PWR), .SETTLE(SET)) dut_i (
    .clk(clk), .rst_n(rst_n), .conv_start_i(strobe), .cmp_i(cmp), .sclk_i(sclk),
    .dout_o(dout), .dac_o(dac), .status_o(status)
  );

  // behavioural reference model
  int mst, tmr, mcode, mres, mbits;
  logic pstart, psclk, men, mact;
  logic [FRAME-1:0] msh;

  always @(posedge clk) begin
    logic rs, fs, sr, sf, done, rend, oldact;
    if (!rst_n) begin
      mst = 0; tmr = 0; mcode = 0; mres = 0; mbits = 0;
      pstart = 0; psclk = 0; men = 0; mact = 0; msh = '0;
    end else begin
      rs = strobe && !pstart; fs = !strobe && pstart;
      sr = sclk && !psclk;    sf = !sclk && psclk;
      pstart = strobe; psclk = sclk;
      done = 0;
      case (mst)
        0: if (rs) begin mst = 1; tmr = PWR; end
        1: begin tmr--; if (tmr == 0) mst = 2; end
        2: if (fs) begin mst = 3; tmr = CONVT; mcode = (vin > 1023) ? 1023 : vin; end
        default: begin
          tmr--;
          if (tmr == 0) begin done = 1; mres = mcode; mst = strobe ? 2 : 0; end
        end
      endcase
      oldact = mact; rend = 0;
      if (sf && oldact) begin
        if (mbits == FRAME - 1) rend = 1; else msh = msh << 1;
        mbits++;
      end
      if (rend) mact = 0;
      else if (!oldact && sr && men) begin mact = 1; mbits = 0; end
      if (rend || (done && !oldact)) msh = FRAME'(mres);
      if (rs) men = 1; else if (done && !strobe) men = 0;
    end
  end

  always @(negedge clk) if (rst_n && !finished) begin
    total++;
    if (status !== 2'(mst)) begin
      bad++; $display("FAIL R2/R3/R5/R6 status act=%0d exp=%0d at %0t", status, mst, $time);
    end
    total++;
    if (dout !== msh[FRAME-1]) begin
      bad++; $display("FAIL R7 dout act=%0b exp=%0b at %0t", dout, msh[FRAME-1], $time);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s act=%0d exp=%0d", tag, act, exp); end
  endtask

  task automatic read_frame(output int val);
    val = 0;
    for (int i = 0; i < FRAME; i++) begin
      sclk = 1'b1; tick(2);
      val = (val << 1) | int'(dout);
      sclk = 1'b0; tick(2);
    end
  endtask

  task automatic power_up();
    strobe = 1'b1; tick(1);
    chk(status == 2'd1, "R2 powering up", status, 1);
    tick(PWR - 1);
    chk(status == 2'd1, "R2 still powering up", status, 1);
    tick(1);
    chk(status == 2'd2, "R2 tracking after power-up", status, 2);
  endtask

  task automatic conv_m1(input int v);
    vin = v; strobe = 1'b0; tick(1);
    chk(status == 2'd3, "R3 converting", status, 3);
    strobe = 1'b1; tick(CONVT - 1);
    chk(status == 2'd3, "R3 conversion length", status, 3);
    tick(1);
    chk(status == 2'd2, "R5 stays powered", status, 2);
  endtask

  task automatic conv_m2(input int v);
    vin = v; strobe = 1'b0; tick(CONVT + 1);
    chk(status == 2'd0, "R6 auto power-down", status, 0);
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int g;
    int vals[6] = '{0, 1023, 512, 1, 1100, 341};
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk(status == 2'd0, "R1 status off", status, 0);
    chk(dout == 1'b0, "R1 dout low", dout, 0);
    chk(dac == '0, "R1 dac idle", dac, 0);

    power_up();
    chk(dac == '0, "R11 dac idle while tracking", dac, 0);
    conv_m1(677);
    read_frame(g);
    chk(g == 677, "R4 R7 frame", g, 677);

    foreach (vals[i]) begin
      conv_m1(vals[i]);
      read_frame(g);
      chk(g == ((vals[i] > 1023) ? 1023 : vals[i]), "R4 code", g, (vals[i] > 1023) ? 1023 : vals[i]);
    end

    conv_m1(100);
    read_frame(g);
    chk(g == 100, "R4 code", g, 100);
    vin = 900; strobe = 1'b0; tick(1);
    strobe = 1'b1; tick(1);
    read_frame(g);
    chk(g == 100, "R8 early read gives previous", g, 100);
    read_frame(g);
    chk(g == 900, "R9 held result after read", g, 900);

    conv_m2(321);
    read_frame(g);
    chk(g == 0, "R10 clocks ignored while off", g, 0);
    power_up();
    read_frame(g);
    chk(g == 321, "R10 frame intact after wake", g, 321);

    conv_m2(55);
    strobe = 1'b1; tick(1);
    strobe = 1'b0; tick(PWR);
    chk(status == 2'd2, "R3 fall during power-up ignored", status, 2);
    read_frame(g);
    chk(g == 55, "R6 result kept across power-down", g, 55);
    strobe = 1'b1; tick(3);
    chk(status == 2'd2, "R2 rise while tracking", status, 2);
    conv_m1(77);
    read_frame(g);
    chk(g == 77, "R4 code after wake", g, 77);
    chk(dac == '0, "R11 dac idle after conversion", dac, 0);

    tick(2);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule